// File: doc/BRIEF.md
# AXI to TileLink-UL Bridge

This block sits between an AXI4 slave port and a TileLink Uncached Lightweight master port. Each AXI transaction is a single beat. A write arrives as an address beat and a data beat presented together. A read arrives as one address beat. Either kind becomes a single request on the TileLink A channel. The AXI transaction ID travels as the TileLink source tag, so the response can be routed back without a lookup table.

Responses come back on the TileLink D channel. An acknowledge without data becomes an AXI write response. An acknowledge with data becomes an AXI read beat. The D error flag becomes a slave-error response code.

There is only one A channel. When a write and a read arrive in the same cycle, the write goes first. No new AXI request is taken until the pending A request has been accepted downstream.

Top module: `axi_tlul_bridge`

## Requirements
- R1: `aw_ready` and `w_ready` rise together, and only in a cycle where `aw_valid` and `w_valid` are both high and no A request is pending. The address beat and the data beat are taken on the same clock edge.
- R2: A write taken on an edge appears on the A channel from the next cycle. It carries `a_opcode` = 0 (full put), and `a_address`, `a_size` and `a_data` equal to the AXI values. `a_source` equals `aw_id` and `a_mask` equals `w_strb`. Every size code from 0 to 5 passes through unchanged.
- R3: A read taken on an edge appears on the A channel from the next cycle. It carries `a_opcode` = 4 (get), with `a_address`, `a_size` and `a_source` = `ar_id`, `a_mask` all ones and `a_data` zero. Every size code from 0 to 5 passes through unchanged.
- R4: While `a_valid` is high and `a_ready` is low, every A-channel output holds its value. `a_valid` falls in the cycle after the edge on which `a_ready` is seen high.
- R5: While an A request is pending, `aw_ready`, `w_ready` and `ar_ready` stay low, whatever the AXI valids are.
- R6: When an idle bridge sees a complete write and a read together, the write is taken and `ar_ready` stays low. The read is taken once the write's A request has been accepted.
- R7: A D beat with `d_opcode` = 0 (acknowledge) raises `b_valid`, with `b_id` = `d_source`. `b_resp` is 0 when `d_error` is clear and 2 when it is set.
- R8: A D beat with `d_opcode` = 1 (acknowledge with data) raises `r_valid`, with `r_id` = `d_source`, `r_data` = `d_data` and `r_last` = 1. `r_resp` is 0 when `d_error` is clear and 2 when it is set. The data is forwarded in both cases.
- R9: `d_ready` follows `b_ready` for opcode 0 and `r_ready` for opcode 1. A D beat with any other opcode is consumed at once (`d_ready` = 1) and raises neither `b_valid` nor `r_valid`.
- R10: After a synchronous active-low reset with all valids low, `a_valid`, `b_valid`, `r_valid` and all three AXI request readies are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| aw_valid | input | 1 | Write address valid |
| aw_ready | output | 1 | Write address ready |
| aw_addr | input | 32 | Write address |
| aw_id | input | 6 | Write transaction ID |
| aw_size | input | 3 | Write size, log2 bytes |
| w_valid | input | 1 | Write data valid |
| w_ready | output | 1 | Write data ready |
| w_data | input | 256 | Write data |
| w_strb | input | 32 | Write byte strobes |
| b_valid | output | 1 | Write response valid |
| b_ready | input | 1 | Write response ready |
| b_id | output | 6 | Write response ID |
| b_resp | output | 2 | Write response code |
| ar_valid | input | 1 | Read address valid |
| ar_ready | output | 1 | Read address ready |
| ar_addr | input | 32 | Read address |
| ar_id | input | 6 | Read transaction ID |
| ar_size | input | 3 | Read size, log2 bytes |
| r_valid | output | 1 | Read data valid |
| r_ready | input | 1 | Read data ready |
| r_id | output | 6 | Read data ID |
| r_data | output | 256 | Read data |
| r_resp | output | 2 | Read response code |
| r_last | output | 1 | Last read beat, always 1 |
| a_valid | output | 1 | TileLink A valid |
| a_ready | input | 1 | TileLink A ready |
| a_opcode | output | 3 | TileLink A opcode |
| a_address | output | 32 | TileLink A address |
| a_source | output | 6 | TileLink A source tag |
| a_size | output | 3 | TileLink A size, log2 bytes |
| a_data | output | 256 | TileLink A data |
| a_mask | output | 32 | TileLink A byte mask |
| d_valid | input | 1 | TileLink D valid |
| d_ready | output | 1 | TileLink D ready |
| d_opcode | input | 3 | TileLink D opcode |
| d_source | input | 6 | TileLink D source tag |
| d_data | input | 256 | TileLink D data |
| d_error | input | 1 | TileLink D error flag |

## Verification
The assertions take for granted a well-behaved AXI master: its address and data fields stay steady while a valid is high. They also assume the downstream TileLink side returns D beats whose opcode matches the request that was issued.

The stimulus meets both assumptions. It changes inputs only on the falling clock edge, and it holds each request until the handshake has been checked. It presents D beats only with the opcode under test.

The bench sweeps every size code for reads and for writes, across several IDs and data patterns, and sweeps the error flag for both response kinds. The expected fields are built arithmetically from the sweep index.

// File: rtl/atb_pkg.sv
// Package: shared constants and opcode encodings for the AXI to TileLink-UL bridge.
// Assumes single-beat traffic; the widths here are the defaults of the top module.
package atb_pkg;
    localparam int OPC_W = 3;
    localparam int RSP_W = 2;

    typedef enum logic [OPC_W-1:0] {
        A_PUT_FULL    = 3'd0,
        A_PUT_PARTIAL = 3'd1,
        A_GET         = 3'd4
    } a_opc_e;

    typedef enum logic [OPC_W-1:0] {
        D_ACK      = 3'd0,
        D_ACK_DATA = 3'd1
    } d_opc_e;

    localparam logic [RSP_W-1:0] RSP_OKAY   = 2'd0;
    localparam logic [RSP_W-1:0] RSP_SLVERR = 2'd2;
endpackage

// File: rtl/atb_arb.sv
// Module: request arbiter. Decides which AXI request is taken onto the single
// A channel this cycle. A write needs its address and data beats present
// together and wins over a read. Nothing is taken while a request is pending.
// Assumes the pending flag comes from the A-channel holding register.
module atb_arb (
    input  logic pend,
    input  logic aw_valid,
    input  logic w_valid,
    input  logic ar_valid,
    output logic aw_ready,
    output logic w_ready,
    output logic ar_ready,
    output logic take_wr,
    output logic take_rd
);
    // Fixed priority select: a write first, then a read, only while idle.
    always_comb begin
        take_wr  = !pend && aw_valid && w_valid;
        take_rd  = !pend && ar_valid && !(aw_valid && w_valid);
        aw_ready = take_wr;
        w_ready  = take_wr;
        ar_ready = take_rd;
    end
endmodule

// File: rtl/atb_a_hold.sv
// Module: A-channel holding register. It captures the chosen AXI request on
// the edge where that request is taken, and presents the request from the
// next cycle. It holds the request until the downstream side accepts it.
// Assumes take_wr and take_rd are never high together.
module atb_a_hold
    import atb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int ID_W   = 6,
    parameter int DATA_W = 256,
    parameter int SIZE_W = 3,
    localparam int MASK_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_wr,
    input  logic              take_rd,
    input  logic [ADDR_W-1:0] aw_addr,
    input  logic [ID_W-1:0]   aw_id,
    input  logic [SIZE_W-1:0] aw_size,
    input  logic [DATA_W-1:0] w_data,
    input  logic [MASK_W-1:0] w_strb,
    input  logic [ADDR_W-1:0] ar_addr,
    input  logic [ID_W-1:0]   ar_id,
    input  logic [SIZE_W-1:0] ar_size,
    input  logic              a_ready,
    output logic              a_valid,
    output logic [OPC_W-1:0]  a_opcode,
    output logic [ADDR_W-1:0] a_address,
    output logic [ID_W-1:0]   a_source,
    output logic [SIZE_W-1:0] a_size,
    output logic [DATA_W-1:0] a_data,
    output logic [MASK_W-1:0] a_mask
);
    // Pending flag: set when a request is taken, cleared on the A handshake.
    always_ff @(posedge clk) begin
        if (!rst_n)
            a_valid <= 1'b0;
        else if (take_wr || take_rd)
            a_valid <= 1'b1;
        else if (a_valid && a_ready)
            a_valid <= 1'b0;
    end

    // Payload capture: the fields load only on the edge a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_opcode  <= A_PUT_FULL;
            a_address <= '0;
            a_source  <= '0;
            a_size    <= '0;
            a_data    <= '0;
            a_mask    <= '0;
        end else if (take_wr) begin
            a_opcode  <= A_PUT_FULL;
            a_address <= aw_addr;
            a_source  <= aw_id;
            a_size    <= aw_size;
            a_data    <= w_data;
            a_mask    <= w_strb;
        end else if (take_rd) begin
            a_opcode  <= A_GET;
            a_address <= ar_addr;
            a_source  <= ar_id;
            a_size    <= ar_size;
            a_data    <= '0;
            a_mask    <= '1;
        end
    end

    // R4: a stalled request keeps every field.
    p_a_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (a_valid && !a_ready) |=> (a_valid && $stable(a_opcode) && $stable(a_address)
            && $stable(a_source) && $stable(a_size) && $stable(a_data) && $stable(a_mask)));

    // R4: the request drops once it is accepted.
    p_a_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (a_valid && a_ready) |=> !a_valid);
endmodule

// File: rtl/atb_d_route.sv
// Module: D-channel router. Sends an acknowledge to the AXI write response
// channel and an acknowledge with data to the AXI read channel. The error
// flag becomes a slave-error code. D is consumed only when the matching AXI
// response is taken in the same cycle. Other opcodes are consumed and dropped.
// Assumes the downstream side returns one response per issued request.
module atb_d_route
    import atb_pkg::*;
#(
    parameter int ID_W   = 6,
    parameter int DATA_W = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              d_valid,
    input  logic [OPC_W-1:0]  d_opcode,
    input  logic [ID_W-1:0]   d_source,
    input  logic [DATA_W-1:0] d_data,
    input  logic              d_error,
    output logic              d_ready,
    output logic              b_valid,
    input  logic              b_ready,
    output logic [ID_W-1:0]   b_id,
    output logic [RSP_W-1:0]  b_resp,
    output logic              r_valid,
    input  logic              r_ready,
    output logic [ID_W-1:0]   r_id,
    output logic [DATA_W-1:0] r_data,
    output logic [RSP_W-1:0]  r_resp,
    output logic              r_last
);
    logic is_ack;
    logic is_data;
    logic [RSP_W-1:0] code;

    // Opcode decode and response code selection.
    always_comb begin
        is_ack  = (d_opcode == D_ACK);
        is_data = (d_opcode == D_ACK_DATA);
        code    = d_error ? RSP_SLVERR : RSP_OKAY;
    end

    // Route the beat to the AXI response channel its opcode selects.
    always_comb begin
        b_valid = d_valid && is_ack;
        b_id    = d_source;
        b_resp  = code;
        r_valid = d_valid && is_data;
        r_id    = d_source;
        r_data  = d_data;
        r_resp  = code;
        r_last  = 1'b1;
        if (is_ack)
            d_ready = b_ready;
        else if (is_data)
            d_ready = r_ready;
        else
            d_ready = 1'b1;
    end

    // R9: an acknowledge is consumed only together with a write response.
    p_ack_paired_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && d_ready && d_opcode == 3'd0) |-> (b_valid && b_ready));

    // R9: an acknowledge with data is consumed only together with a read beat.
    p_data_paired_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && d_ready && d_opcode == 3'd1) |-> (r_valid && r_ready));

    // R9: the two AXI response channels are never driven by one beat.
    p_one_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(b_valid && r_valid));
endmodule

// File: rtl/axi_tlul_bridge.sv
// Module: top of the AXI4 single-beat to TileLink-UL bridge. It ties the
// request arbiter, the A-channel holding register and the D-channel router
// together. Assumes AXI fields stay stable while their valid is high, and
// at most one outstanding request per direction.
module axi_tlul_bridge
    import atb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int ID_W   = 6,
    parameter int DATA_W = 256,
    parameter int SIZE_W = 3,
    localparam int MASK_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              aw_valid,
    output logic              aw_ready,
    input  logic [ADDR_W-1:0] aw_addr,
    input  logic [ID_W-1:0]   aw_id,
    input  logic [SIZE_W-1:0] aw_size,
    input  logic              w_valid,
    output logic              w_ready,
    input  logic [DATA_W-1:0] w_data,
    input  logic [MASK_W-1:0] w_strb,
    output logic              b_valid,
    input  logic              b_ready,
    output logic [ID_W-1:0]   b_id,
    output logic [1:0]        b_resp,
    input  logic              ar_valid,
    output logic              ar_ready,
    input  logic [ADDR_W-1:0] ar_addr,
    input  logic [ID_W-1:0]   ar_id,
    input  logic [SIZE_W-1:0] ar_size,
    output logic              r_valid,
    input  logic              r_ready,
    output logic [ID_W-1:0]   r_id,
    output logic [DATA_W-1:0] r_data,
    output logic [1:0]        r_resp,
    output logic              r_last,
    output logic              a_valid,
    input  logic              a_ready,
    output logic [2:0]        a_opcode,
    output logic [ADDR_W-1:0] a_address,
    output logic [ID_W-1:0]   a_source,
    output logic [SIZE_W-1:0] a_size,
    output logic [DATA_W-1:0] a_data,
    output logic [MASK_W-1:0] a_mask,
    input  logic              d_valid,
    output logic              d_ready,
    input  logic [2:0]        d_opcode,
    input  logic [ID_W-1:0]   d_source,
    input  logic [DATA_W-1:0] d_data,
    input  logic              d_error
);
    logic take_wr;
    logic take_rd;

    atb_arb u_arb (
        .pend     (a_valid),
        .aw_valid (aw_valid),
        .w_valid  (w_valid),
        .ar_valid (ar_valid),
        .aw_ready (aw_ready),
        .w_ready  (w_ready),
        .ar_ready (ar_ready),
        .take_wr  (take_wr),
        .take_rd  (take_rd)
    );

    atb_a_hold #(
        .ADDR_W (ADDR_W),
        .ID_W   (ID_W),
        .DATA_W (DATA_W),
        .SIZE_W (SIZE_W)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_wr   (take_wr),
        .take_rd   (take_rd),
        .aw_addr   (aw_addr),
        .aw_id     (aw_id),
        .aw_size   (aw_size),
        .w_data    (w_data),
        .w_strb    (w_strb),
        .ar_addr   (ar_addr),
        .ar_id     (ar_id),
        .ar_size   (ar_size),
        .a_ready   (a_ready),
        .a_valid   (a_valid),
        .a_opcode  (a_opcode),
        .a_address (a_address),
        .a_source  (a_source),
        .a_size    (a_size),
        .a_data    (a_data),
        .a_mask    (a_mask)
    );

    atb_d_route #(
        .ID_W   (ID_W),
        .DATA_W (DATA_W)
    ) u_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .d_valid  (d_valid),
        .d_opcode (d_opcode),
        .d_source (d_source),
        .d_data   (d_data),
        .d_error  (d_error),
        .d_ready  (d_ready),
        .b_valid  (b_valid),
        .b_ready  (b_ready),
        .b_id     (b_id),
        .b_resp   (b_resp),
        .r_valid  (r_valid),
        .r_ready  (r_ready),
        .r_id     (r_id),
        .r_data   (r_data),
        .r_resp   (r_resp),
        .r_last   (r_last)
    );

    // R1: write readies only with both write beats present and no request pending.
    p_wr_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        aw_ready |-> (aw_valid && w_valid && w_ready && !a_valid));

    // R5: no request is taken while A is pending.
    p_hold_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        a_valid |-> (!aw_ready && !w_ready && !ar_ready));

    // R6: a complete write beats a simultaneous read.
    p_wr_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (aw_valid && w_valid) |-> !ar_ready);

    // R2: a taken write becomes a full-put request on the next cycle.
    p_wr_to_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (aw_valid && aw_ready) |=> (a_valid && a_opcode == 3'd0));

    // R3: a taken read becomes a get request on the next cycle.
    p_rd_to_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ar_valid && ar_ready) |=> (a_valid && a_opcode == 3'd4));
endmodule

// File: tb/sim_axi_tlul_bridge.sv
module sim_axi_tlul_bridge;
    localparam int AW = 32, IW = 6, DW = 256, SW = 3, MW = DW / 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic aw_valid = 0, w_valid = 0, ar_valid = 0, b_ready = 0, r_ready = 0;
    logic a_ready = 0, d_valid = 0, d_error = 0;
    logic [AW-1:0] aw_addr = '0, ar_addr = '0;
    logic [IW-1:0] aw_id = '0, ar_id = '0, d_source = '0;
    logic [SW-1:0] aw_size = '0, ar_size = '0;
    logic [DW-1:0] w_data = '0, d_data = '0;
    logic [MW-1:0] w_strb = '0;
    logic [2:0]    d_opcode = '0;
    logic aw_ready, w_ready, ar_ready, b_valid, r_valid, r_last, a_valid, d_ready;
    logic [IW-1:0] b_id, r_id, a_source;
    logic [1:0]    b_resp, r_resp;
    logic [DW-1:0] r_data, a_data;
    logic [2:0]    a_opcode;
    logic [AW-1:0] a_address;
    logic [SW-1:0] a_size;
    logic [MW-1:0] a_mask;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    axi_tlul_bridge u0 (.*);

    task automatic chk(input logic ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int k);
        logic [DW-1:0] v;
        for (int i = 0; i < DW / 32; i++)
            v[i*32 +: 32] = 32'h9E37_79B9 * (k + 1) + i * 32'h0101_0101;
        return v;
    endfunction

    // Accept the pending A request and check that it drops (R4).
    task automatic release_a(input string tag);
        @(negedge clk);
        a_ready = 1'b1;
        @(negedge clk);
        a_ready = 1'b0;
        #1;
        chk(a_valid == 1'b0, tag, DW'(a_valid), DW'(0));
    endtask

    task automatic do_write(input int k);
        logic [AW-1:0] ad = 32'h1000_0000 + k * 32'h0004_0010;
        logic [IW-1:0] id = IW'(k * 7 + 3);
        logic [SW-1:0] sz = SW'(k % 6);
        logic [MW-1:0] sb = MW'((64'd1 << (1 << (k % 6))) - 1);
        @(negedge clk);
        aw_valid = 1; w_valid = 1; aw_addr = ad; aw_id = id; aw_size = sz;
        w_data = pat(k); w_strb = sb;
        #1;
        chk(aw_ready && w_ready, "R1 paired readies", DW'({aw_ready, w_ready}), DW'(3));
        @(negedge clk);
        aw_valid = 0; w_valid = 0;
        #1;
        chk(a_valid && a_opcode == 3'd0, "R2 opcode", DW'(a_opcode), DW'(0));
        chk(a_address == ad && a_source == id && a_size == sz, "R2 addr/src/size",
            DW'({a_address, a_source, a_size}), DW'({ad, id, sz}));
        chk(a_data == pat(k) && a_mask == sb, "R2 data/mask", a_data ^ DW'(a_mask),
            pat(k) ^ DW'(sb));
        // R5: offer a read and a write while pending; both are refused.
        ar_valid = 1; aw_valid = 1; w_valid = 1;
        #1;
        chk(!ar_ready && !aw_ready && !w_ready, "R5 held off",
            DW'({ar_ready, aw_ready, w_ready}), DW'(0));
        @(negedge clk);
        ar_valid = 0; aw_valid = 0; w_valid = 0;
        #1;
        chk(a_valid && a_address == ad && a_data == pat(k), "R4 stable while stalled",
            DW'(a_address), DW'(ad));
        release_a("R4 drop after write");
    endtask

    task automatic do_read(input int k);
        logic [AW-1:0] ad = 32'hC000_0100 + k * 32'h0000_1020;
        logic [IW-1:0] id = IW'(63 - k * 5);
        logic [SW-1:0] sz = SW'(5 - (k % 6));
        @(negedge clk);
        ar_valid = 1; ar_addr = ad; ar_id = id; ar_size = sz;
        #1;
        chk(ar_ready && !aw_ready, "R3 read taken", DW'(ar_ready), DW'(1));
        @(negedge clk);
        ar_valid = 0;
        #1;
        chk(a_valid && a_opcode == 3'd4, "R3 opcode", DW'(a_opcode), DW'(4));
        chk(a_address == ad && a_source == id && a_size == sz, "R3 addr/src/size",
            DW'({a_address, a_source, a_size}), DW'({ad, id, sz}));
        chk(a_mask == '1 && a_data == '0, "R3 mask/data", DW'(a_mask), DW'({MW{1'b1}}));
        release_a("R4 drop after read");
    endtask

    task automatic do_resp(input logic [2:0] opc, input logic err, input int k);
        logic [IW-1:0] id = IW'(k * 11 + 1);
        logic [1:0] exp_rsp = err ? 2'd2 : 2'd0;
        @(negedge clk);
        d_valid = 1; d_opcode = opc; d_error = err; d_source = id; d_data = pat(k + 40);
        b_ready = 0; r_ready = 0;
        #1;
        if (opc == 3'd0) begin
            chk(b_valid && !r_valid && b_id == id && b_resp == exp_rsp, "R7 write response",
                DW'({b_valid, b_id, b_resp}), DW'({1'b1, id, exp_rsp}));
            chk(!d_ready, "R9 stall without b_ready", DW'(d_ready), DW'(0));
            b_ready = 1;
            #1;
            chk(d_ready, "R9 follows b_ready", DW'(d_ready), DW'(1));
        end else if (opc == 3'd1) begin
            chk(r_valid && !b_valid && r_id == id && r_resp == exp_rsp && r_last,
                "R8 read beat", DW'({r_valid, r_id, r_resp, r_last}),
                DW'({1'b1, id, exp_rsp, 1'b1}));
            chk(r_data == pat(k + 40), "R8 read data", r_data, pat(k + 40));
            chk(!d_ready, "R9 stall without r_ready", DW'(d_ready), DW'(0));
            r_ready = 1;
            #1;
            chk(d_ready, "R9 follows r_ready", DW'(d_ready), DW'(1));
        end else begin
            chk(d_ready && !b_valid && !r_valid, "R9 other opcode dropped",
                DW'({d_ready, b_valid, r_valid}), DW'(3'b100));
        end
        @(negedge clk);
        d_valid = 0; b_ready = 0; r_ready = 0;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10: reset state.
        chk(!a_valid && !b_valid && !r_valid && !aw_ready && !w_ready && !ar_ready,
            "R10 reset state", DW'({a_valid, b_valid, r_valid, aw_ready, w_ready, ar_ready}),
            DW'(0));
        // R1: address alone is not taken.
        @(negedge clk);
        aw_valid = 1;
        #1;
        chk(!aw_ready && !w_ready, "R1 address alone", DW'({aw_ready, w_ready}), DW'(0));
        @(negedge clk);
        aw_valid = 0; w_valid = 1;
        #1;
        chk(!aw_ready && !w_ready, "R1 data alone", DW'({aw_ready, w_ready}), DW'(0));
        @(negedge clk);
        w_valid = 0;
        for (int k = 0; k < 12; k++) do_write(k);
        for (int k = 0; k < 12; k++) do_read(k);
        // R6: simultaneous write and read.
        @(negedge clk);
        aw_valid = 1; w_valid = 1; aw_addr = 32'hAAAA_0000; aw_id = 6'd9; aw_size = 3'd2;
        w_data = pat(99); w_strb = 32'h0000_000F;
        ar_valid = 1; ar_addr = 32'h5555_0000; ar_id = 6'd17; ar_size = 3'd3;
        #1;
        chk(aw_ready && !ar_ready, "R6 write wins", DW'({aw_ready, ar_ready}), DW'(2'b10));
        @(negedge clk);
        aw_valid = 0; w_valid = 0;
        #1;
        chk(a_opcode == 3'd0 && a_source == 6'd9, "R6 write issued first",
            DW'({a_opcode, a_source}), DW'({3'd0, 6'd9}));
        @(negedge clk);
        a_ready = 1;
        @(negedge clk);
        a_ready = 0;
        #1;
        chk(ar_ready, "R6 read taken after write", DW'(ar_ready), DW'(1));
        @(negedge clk);
        ar_valid = 0;
        #1;
        chk(a_opcode == 3'd4 && a_source == 6'd17 && a_address == 32'h5555_0000,
            "R6 read issued second", DW'({a_opcode, a_source}), DW'({3'd4, 6'd17}));
        release_a("R4 drop after arbitration");
        for (int k = 0; k < 4; k++) begin
            do_resp(3'd0, k[0], k);
            do_resp(3'd1, k[0], k);
        end
        do_resp(3'd2, 1'b0, 5);
        do_resp(3'd7, 1'b1, 6);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule